// File: doc/BRIEF.md
# Instruction Cache-Line Fetch Controller

This block sits at the head of a processor front end. It keeps one 64-byte instruction line in a local register and cuts instructions out of it for the current program counter. It hands up to a configured number of them per cycle to a downstream instruction buffer. When the program counter leaves the held line, or no line is held, the controller sends a single line-aligned read request to the memory side and waits for the matching response. Only one request is ever in flight.

The memory side may refuse a request. The controller then keeps the request and stays quiet until a retry notification arrives, and resends it at that point. Every request carries a small tag. A redirect (squash) moves the program counter, abandons any pending or held request and advances the tag. A response that arrives late for an abandoned request therefore fails the tag match; it is dropped and counted. A fault reported by address translation for a due fetch puts one fault-marked record into the buffer. The controller then holds until the next redirect. After a line arrives, the controller can be held off by an external register-shortage or barrier condition. Three event counters report stalled cycles, accepted line requests and dropped responses.

Top module: `fetch_line_ctl`

## Requirements
- R1: After reset the program counter holds RESET_PC (0x100 by default), no line is valid, all three counters read zero, no lane is valid, and the controller immediately requests the line of RESET_PC with tag 0.
- R2: A line request drives `req_addr_o` as the program counter with its low six bits cleared, and `req_tag_o` as the current tag. A request that is accepted in the cycle it is driven increments `line_cnt_o` by one. No request is driven in the cycle after it.
- R3: A refused request puts the controller in a retry wait. In this wait `req_valid_o` stays low while `retry_i` is low. While `retry_i` is high the same address and tag are driven again. Acceptance moves the controller to the response wait and increments `line_cnt_o`.
- R4: A response is taken only in the response wait with `rsp_tag_i` equal to the current tag and no squash in that cycle. Every other asserted `rsp_valid_i` is discarded and increments `stale_cnt_o` by one.
- R5: After a response is taken the line becomes valid. If `regs_empty_i` is high the controller enters a rename hold, which is left only when `regs_empty_i` is low. Otherwise, if `barrier_hold_i` is high, it enters a barrier hold, which is left only when `barrier_hold_i` is low. Otherwise it runs. In both holds no lane and no request is driven.
- R6: While running on a valid line, lane i (i = 0..WIDTH-1) carries address pc+4i and the 32-bit word at index pc[5:2]+i of the line, taken from line bits [32*index +: 32]. The lanes are valid as a contiguous group from lane 0. Their count is the smallest of WIDTH, `buf_free_i`, the words left in the line, and the position of the first lane with `pred_taken_i` set, that lane itself included. The program counter moves to that lane's `pred_target_i` if a valid lane is predicted taken, and otherwise advances by four per valid lane.
- R7: When the program counter has left the held line, the next cycle delivers no lanes and drives a request for the new line.
- R8: A squash loads `squash_pc_i`, advances the tag by one, drops any held or pending request, invalidates the line and returns to running. In the squash cycle no lane and no request is driven. A later response carrying the old tag is counted as stale.
- R9: `stall_cnt_o` increments by one for every cycle spent in the retry wait or the response wait.
- R10: If a fetch is due while `xlate_fault_i` is high and `buf_free_i` is non-zero, lane 0 alone is valid with `out_fault_o` high and address equal to the program counter, and no request is driven. The controller then delivers nothing and requests nothing until a squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| squash_i | input | 1 | Redirect the fetch stream |
| squash_pc_i | input | ADDR_W | New program counter on redirect |
| xlate_fault_i | input | 1 | Translation of the due fetch faults |
| barrier_hold_i | input | 1 | A serializing barrier is outstanding |
| regs_empty_i | input | 1 | No free rename registers remain |
| req_valid_o | output | 1 | Line read request |
| req_addr_o | output | ADDR_W | Line-aligned request address |
| req_tag_o | output | TAG_W | Tag of the request |
| req_accept_i | input | 1 | Memory side accepts the request this cycle |
| retry_i | input | 1 | Memory side invites a resend |
| rsp_valid_i | input | 1 | Response present |
| rsp_tag_i | input | TAG_W | Tag carried by the response |
| rsp_line_i | input | LINE_BYTES*8 | Line data of the response |
| buf_free_i | input | FREE_W | Free slots in the downstream buffer |
| pred_taken_i | input | WIDTH | Per-lane predicted-taken flag |
| pred_target_i | input | WIDTH*ADDR_W | Per-lane predicted target |
| out_valid_o | output | WIDTH | Lane valid flags |
| out_pc_o | output | WIDTH*ADDR_W | Lane addresses |
| out_insn_o | output | WIDTH*32 | Lane instruction words |
| out_fault_o | output | 1 | Lane 0 is a fault record |
| stall_cnt_o | output | CNT_W | Cycles waiting on memory |
| line_cnt_o | output | CNT_W | Accepted line requests |
| stale_cnt_o | output | CNT_W | Discarded responses |

## Verification
Extraction is driven with a full buffer, a partly full buffer, a predicted-taken lane in the middle of the group, and a program counter on the last word of the line. Each of these ends the lane group for a different reason, and the next group's start address shows whether the program counter advanced correctly. The request path is driven with immediate acceptance, with refusal followed by a refused and then an accepted retry, and with a squash during a pending response followed by a late response carrying the old tag. This separates a held request from a new one and a live response from a stale one. The post-response holds are tried with the barrier alone and with both conditions raised, and the release order shows which hold was entered.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;

    typedef enum logic [2:0] {
        FS_RUN        = 3'd0,
        FS_WAIT_RETRY = 3'd1,
        FS_WAIT_RSP   = 3'd2,
        FS_SER_BLK    = 3'd3,
        FS_REN_BLK    = 3'd4,
        FS_TRAP       = 3'd5
    } fetch_state_e;

endpackage

// File: rtl/fetch_evt_cnt.sv
module fetch_evt_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/fetch_lane_pick.sv
module fetch_lane_pick #(
    parameter int ADDR_W = 32,
    parameter int WIDTH  = 4,
    parameter int WORDS  = 16,
    parameter int OFF_W  = 6,
    parameter int FREE_W = 3
) (
    input  logic                    enable_i,
    input  logic [ADDR_W-1:0]       pc_i,
    input  logic [FREE_W-1:0]       buf_free_i,
    input  logic [WIDTH-1:0]        pred_taken_i,
    input  logic [WIDTH*ADDR_W-1:0] pred_target_i,
    output logic [WIDTH-1:0]        lane_valid_o,
    output logic [ADDR_W-1:0]       next_pc_o
);

    localparam int IDX_W = OFF_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic [WIDTH:0]   alive;

    assign word_idx = pc_i[OFF_W-1:2];
    assign alive[0] = enable_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        logic room;
        logic space;
        assign room  = (32'(word_idx) + 32'(i)) < 32'(WORDS);
        assign space = 32'(buf_free_i) > 32'(i);
        assign lane_valid_o[i] = alive[i] & room & space;
        assign alive[i+1]      = lane_valid_o[i] & ~pred_taken_i[i];
    end

    always_comb begin
        int               n;
        logic             hit;
        logic [ADDR_W-1:0] jump;
        n    = 0;
        hit  = 1'b0;
        jump = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (lane_valid_o[i]) n = n + 1;
            if (lane_valid_o[i] && pred_taken_i[i]) begin
                hit  = 1'b1;
                jump = pred_target_i[i*ADDR_W +: ADDR_W];
            end
        end
        next_pc_o = hit ? jump : pc_i + ADDR_W'(n * 4);
    end

    // R6: valid lanes always form a group starting at lane 0
    always_comb begin
        a_r6_lane_prefix: assert ((lane_valid_o & (lane_valid_o + WIDTH'(1))) == '0);
    end

endmodule

// File: rtl/fetch_word_mux.sv
module fetch_word_mux #(
    parameter int WIDTH     = 4,
    parameter int IDX_W     = 4,
    parameter int LINE_BITS = 512
) (
    input  logic [LINE_BITS-1:0] line_i,
    input  logic [IDX_W-1:0]     word_idx_i,
    output logic [WIDTH*32-1:0]  insn_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_word
        logic [IDX_W-1:0] sel;
        assign sel = word_idx_i + IDX_W'(i);
        assign insn_o[i*32 +: 32] = line_i[32*int'(sel) +: 32];
    end

endmodule

// File: rtl/fetch_line_ctl.sv
module fetch_line_ctl
    import fetch_ctl_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                LINE_BYTES = 64,
    parameter int                WIDTH      = 4,
    parameter int                TAG_W      = 2,
    parameter int                CNT_W      = 16,
    parameter logic [ADDR_W-1:0] RESET_PC   = 'h100,
    localparam int               FREE_W     = $clog2(WIDTH + 1),
    localparam int               LINE_BITS  = LINE_BYTES * 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    squash_i,
    input  logic [ADDR_W-1:0]       squash_pc_i,
    input  logic                    xlate_fault_i,
    input  logic                    barrier_hold_i,
    input  logic                    regs_empty_i,
    output logic                    req_valid_o,
    output logic [ADDR_W-1:0]       req_addr_o,
    output logic [TAG_W-1:0]        req_tag_o,
    input  logic                    req_accept_i,
    input  logic                    retry_i,
    input  logic                    rsp_valid_i,
    input  logic [TAG_W-1:0]        rsp_tag_i,
    input  logic [LINE_BITS-1:0]    rsp_line_i,
    input  logic [FREE_W-1:0]       buf_free_i,
    input  logic [WIDTH-1:0]        pred_taken_i,
    input  logic [WIDTH*ADDR_W-1:0] pred_target_i,
    output logic [WIDTH-1:0]        out_valid_o,
    output logic [WIDTH*ADDR_W-1:0] out_pc_o,
    output logic [WIDTH*32-1:0]     out_insn_o,
    output logic                    out_fault_o,
    output logic [CNT_W-1:0]        stall_cnt_o,
    output logic [CNT_W-1:0]        line_cnt_o,
    output logic [CNT_W-1:0]        stale_cnt_o
);

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = OFF_W - 2;
    localparam int WORDS   = LINE_BYTES / 4;
    localparam int BASE_W  = ADDR_W - OFF_W;
    localparam int NUM_CNT = 3;

    typedef struct packed {
        fetch_state_e         state;
        logic [ADDR_W-1:0]    pc;
        logic [BASE_W-1:0]    line_base;
        logic                 line_valid;
        logic [LINE_BITS-1:0] line;
        logic [TAG_W-1:0]     tag;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic                line_hit;
    logic                fetch_due;
    logic                extract_en;
    logic [WIDTH-1:0]    pick_valid;
    logic [ADDR_W-1:0]   pick_next_pc;
    logic                rsp_take;
    logic                fault_lane;
    logic [NUM_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]    cnt_val [NUM_CNT];

    assign line_hit   = ctl_q.line_valid && (ctl_q.pc[ADDR_W-1:OFF_W] == ctl_q.line_base);
    assign fetch_due  = (ctl_q.state == FS_RUN) && !line_hit;
    assign extract_en = (ctl_q.state == FS_RUN) && line_hit && !squash_i;
    assign rsp_take   = rsp_valid_i && (ctl_q.state == FS_WAIT_RSP) &&
                        (rsp_tag_i == ctl_q.tag) && !squash_i;

    fetch_lane_pick #(
        .ADDR_W (ADDR_W),
        .WIDTH  (WIDTH),
        .WORDS  (WORDS),
        .OFF_W  (OFF_W),
        .FREE_W (FREE_W)
    ) i_pick (
        .enable_i      (extract_en),
        .pc_i          (ctl_q.pc),
        .buf_free_i    (buf_free_i),
        .pred_taken_i  (pred_taken_i),
        .pred_target_i (pred_target_i),
        .lane_valid_o  (pick_valid),
        .next_pc_o     (pick_next_pc)
    );

    fetch_word_mux #(
        .WIDTH     (WIDTH),
        .IDX_W     (IDX_W),
        .LINE_BITS (LINE_BITS)
    ) i_mux (
        .line_i     (ctl_q.line),
        .word_idx_i (ctl_q.pc[OFF_W-1:2]),
        .insn_o     (out_insn_o)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pc
        assign out_pc_o[i*ADDR_W +: ADDR_W] = ctl_q.pc + ADDR_W'(4 * i);
    end

    always_comb begin
        ctl_d       = ctl_q;
        req_valid_o = 1'b0;
        fault_lane  = 1'b0;
        req_addr_o  = {ctl_q.pc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        req_tag_o   = ctl_q.tag;

        unique case (ctl_q.state)
            FS_RUN: begin
                if (fetch_due) begin
                    if (xlate_fault_i) begin
                        if (buf_free_i != '0) begin
                            fault_lane  = 1'b1;
                            ctl_d.state = FS_TRAP;
                        end
                    end else begin
                        req_valid_o      = 1'b1;
                        ctl_d.line_base  = ctl_q.pc[ADDR_W-1:OFF_W];
                        ctl_d.line_valid = 1'b0;
                        ctl_d.state      = req_accept_i ? FS_WAIT_RSP : FS_WAIT_RETRY;
                    end
                end else begin
                    ctl_d.pc = pick_next_pc;
                end
            end
            FS_WAIT_RETRY: begin
                req_addr_o = {ctl_q.line_base, {OFF_W{1'b0}}};
                if (retry_i) begin
                    req_valid_o = 1'b1;
                    if (req_accept_i) ctl_d.state = FS_WAIT_RSP;
                end
            end
            FS_WAIT_RSP: begin
                if (rsp_take) begin
                    ctl_d.line       = rsp_line_i;
                    ctl_d.line_valid = 1'b1;
                    if (regs_empty_i)        ctl_d.state = FS_REN_BLK;
                    else if (barrier_hold_i) ctl_d.state = FS_SER_BLK;
                    else                     ctl_d.state = FS_RUN;
                end
            end
            FS_SER_BLK: begin
                if (!barrier_hold_i) ctl_d.state = FS_RUN;
            end
            FS_REN_BLK: begin
                if (!regs_empty_i) ctl_d.state = FS_RUN;
            end
            FS_TRAP: begin
                ctl_d.state = FS_TRAP;
            end
            default: ctl_d.state = FS_RUN;
        endcase

        if (squash_i) begin
            req_valid_o      = 1'b0;
            fault_lane       = 1'b0;
            ctl_d.pc         = squash_pc_i;
            ctl_d.tag        = ctl_q.tag + TAG_W'(1);
            ctl_d.line_valid = 1'b0;
            ctl_d.state      = FS_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state      <= FS_RUN;
            ctl_q.pc         <= RESET_PC;
            ctl_q.line_base  <= '0;
            ctl_q.line_valid <= 1'b0;
            ctl_q.line       <= '0;
            ctl_q.tag        <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid_o = fault_lane ? WIDTH'(1) : pick_valid;
    assign out_fault_o = fault_lane;

    assign cnt_inc[0] = (ctl_q.state == FS_WAIT_RETRY) || (ctl_q.state == FS_WAIT_RSP);
    assign cnt_inc[1] = req_valid_o && req_accept_i;
    assign cnt_inc[2] = rsp_valid_i && !rsp_take;

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        fetch_evt_cnt #(.CNT_W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (cnt_inc[c]),
            .cnt_o (cnt_val[c])
        );
    end

    assign stall_cnt_o = cnt_val[0];
    assign line_cnt_o  = cnt_val[1];
    assign stale_cnt_o = cnt_val[2];

    // R2: an accepted request is not followed by another request
    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_accept_i && !squash_i) |=> !req_valid_o);

    // R2: each accepted request bumps the line counter
    a_r2_line_count: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_accept_i) |=> (line_cnt_o == $past(line_cnt_o) + CNT_W'(1)));

    // R3: a held request stays silent until the retry notification
    a_r3_retry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == FS_WAIT_RETRY && !retry_i) |-> !req_valid_o);

    // R3: a refused request is resent with the same address
    a_r3_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_accept_i && !squash_i) |=>
        (!req_valid_o || req_addr_o == $past(req_addr_o)));

    // R4: responses outside the response wait are always counted as stale
    a_r4_stale_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && ctl_q.state != FS_WAIT_RSP) |=>
        (stale_cnt_o == $past(stale_cnt_o) + CNT_W'(1)));

    // R6: never more lanes than downstream free slots
    a_r6_buffer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid_o) <= int'(buf_free_i));

    // R8: a squash cycle drives neither lanes nor a request
    a_r8_squash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        squash_i |-> (out_valid_o == '0 && !req_valid_o));

    // R10: the trap state is silent
    a_r10_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == FS_TRAP) |-> (out_valid_o == '0 && !req_valid_o));

endmodule

// File: tb/test_fetch_line_ctl.sv
module test_fetch_line_ctl;

    localparam int ADDR_W = 32;
    localparam int WIDTH  = 4;
    localparam int TAG_W  = 2;
    localparam int CNT_W  = 16;
    localparam int FREE_W = 3;
    localparam logic [31:0] SALT = 32'hA500_0000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    squash_i = 1'b0;
    logic [ADDR_W-1:0]       squash_pc_i = '0;
    logic                    xlate_fault_i = 1'b0;
    logic                    barrier_hold_i = 1'b0;
    logic                    regs_empty_i = 1'b0;
    logic                    req_valid_o;
    logic [ADDR_W-1:0]       req_addr_o;
    logic [TAG_W-1:0]        req_tag_o;
    logic                    req_accept_i = 1'b0;
    logic                    retry_i = 1'b0;
    logic                    rsp_valid_i = 1'b0;
    logic [TAG_W-1:0]        rsp_tag_i = '0;
    logic [511:0]            rsp_line_i = '0;
    logic [FREE_W-1:0]       buf_free_i = 3'd4;
    logic [WIDTH-1:0]        pred_taken_i = '0;
    logic [WIDTH*ADDR_W-1:0] pred_target_i = '0;
    logic [WIDTH-1:0]        out_valid_o;
    logic [WIDTH*ADDR_W-1:0] out_pc_o;
    logic [WIDTH*32-1:0]     out_insn_o;
    logic                    out_fault_o;
    logic [CNT_W-1:0]        stall_cnt_o;
    logic [CNT_W-1:0]        line_cnt_o;
    logic [CNT_W-1:0]        stale_cnt_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    fetch_line_ctl i_fetch_line_ctl (
        .clk(clk), .rst_n(rst_n), .squash_i(squash_i), .squash_pc_i(squash_pc_i),
        .xlate_fault_i(xlate_fault_i), .barrier_hold_i(barrier_hold_i),
        .regs_empty_i(regs_empty_i), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
        .req_tag_o(req_tag_o), .req_accept_i(req_accept_i), .retry_i(retry_i),
        .rsp_valid_i(rsp_valid_i), .rsp_tag_i(rsp_tag_i), .rsp_line_i(rsp_line_i),
        .buf_free_i(buf_free_i), .pred_taken_i(pred_taken_i), .pred_target_i(pred_target_i),
        .out_valid_o(out_valid_o), .out_pc_o(out_pc_o), .out_insn_o(out_insn_o),
        .out_fault_o(out_fault_o), .stall_cnt_o(stall_cnt_o), .line_cnt_o(line_cnt_o),
        .stale_cnt_o(stale_cnt_o)
    );

    function automatic logic [511:0] mk_line(input logic [31:0] base);
        logic [511:0] l;
        for (int k = 0; k < 16; k++) l[k*32 +: 32] = (base + 32'(4 * k)) ^ SALT;
        return l;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic chk_lanes(input string req, input int n, input logic [31:0] base);
        chk({req, " lane count"}, 64'(out_valid_o), 64'((1 << n) - 1));
        chk({req, " fault flag"}, 64'(out_fault_o), 64'(0));
        for (int i = 0; i < n; i++) begin
            chk({req, " lane pc"}, 64'(out_pc_o[i*32 +: 32]), 64'(base + 32'(4 * i)));
            chk({req, " lane insn"}, 64'(out_insn_o[i*32 +: 32]), 64'((base + 32'(4 * i)) ^ SALT));
        end
    endtask

    task automatic chk_quiet(input string req);
        chk({req, " no lanes"}, 64'(out_valid_o), 64'(0));
        chk({req, " no request"}, 64'(req_valid_o), 64'(0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        settle();
        chk("R1 request after reset", 64'(req_valid_o), 64'(1));
        chk("R1 reset pc line", 64'(req_addr_o), 64'h100);
        chk("R1 tag zero", 64'(req_tag_o), 64'(0));
        chk("R1 no lanes", 64'(out_valid_o), 64'(0));
        chk("R1 counters zero", 64'({stall_cnt_o, line_cnt_o, stale_cnt_o}), 64'(0));
    endtask

    task automatic t_first_line();
        req_accept_i = 1'b1;
        tick();
        req_accept_i = 1'b0;
        settle();
        chk("R2 no request after accept", 64'(req_valid_o), 64'(0));
        chk("R2 line count", 64'(line_cnt_o), 64'(1));
        tick();
        chk("R9 stall counted", 64'(stall_cnt_o), 64'(1));
        rsp_valid_i = 1'b1; rsp_tag_i = 2'd3; rsp_line_i = mk_line(32'h100);
        tick();
        rsp_valid_i = 1'b0;
        settle();
        chk("R4 wrong tag is stale", 64'(stale_cnt_o), 64'(1));
        chk("R4 wrong tag no lanes", 64'(out_valid_o), 64'(0));
        rsp_valid_i = 1'b1; rsp_tag_i = 2'd0;
        tick();
        rsp_valid_i = 1'b0;
        settle();
        chk("R9 stall total", 64'(stall_cnt_o), 64'(3));
        chk("R4 matching tag not stale", 64'(stale_cnt_o), 64'(1));
    endtask

    task automatic t_extract();
        chk_lanes("R6 full width", 4, 32'h100);
        tick();
        buf_free_i = 3'd2;
        settle();
        chk_lanes("R6 buffer limit", 2, 32'h110);
        tick();
        buf_free_i = 3'd4;
        pred_taken_i = 4'b0010;
        pred_target_i[1*32 +: 32] = 32'h13C;
        settle();
        chk_lanes("R6 taken lane ends group", 2, 32'h118);
        tick();
        pred_taken_i = '0;
        settle();
        chk_lanes("R6 line end", 1, 32'h13C);
        tick();
        settle();
        chk("R7 no lanes off line", 64'(out_valid_o), 64'(0));
        chk("R7 new request", 64'(req_valid_o), 64'(1));
        chk("R7 new line addr", 64'(req_addr_o), 64'h140);
    endtask

    task automatic t_retry();
        req_accept_i = 1'b0;
        tick();
        settle();
        chk("R3 quiet in retry wait", 64'(req_valid_o), 64'(0));
        chk("R3 refusal not counted", 64'(line_cnt_o), 64'(1));
        retry_i = 1'b1;
        settle();
        chk("R3 resend on retry", 64'(req_valid_o), 64'(1));
        chk("R3 resend addr", 64'(req_addr_o), 64'h140);
        chk("R3 resend tag", 64'(req_tag_o), 64'(0));
        tick();
        req_accept_i = 1'b1;
        tick();
        retry_i = 1'b0; req_accept_i = 1'b0;
        settle();
        chk("R3 accepted retry counted", 64'(line_cnt_o), 64'(2));
        chk("R3 response wait quiet", 64'(req_valid_o), 64'(0));
    endtask

    task automatic t_barrier();
        barrier_hold_i = 1'b1;
        rsp_valid_i = 1'b1; rsp_tag_i = 2'd0; rsp_line_i = mk_line(32'h140);
        tick();
        rsp_valid_i = 1'b0;
        settle();
        chk_quiet("R5 barrier hold");
        tick();
        chk_quiet("R5 barrier still held");
        barrier_hold_i = 1'b0;
        tick();
        chk_lanes("R5 barrier released", 4, 32'h140);
        buf_free_i = 3'd0;
        settle();
        chk("R6 full buffer no lanes", 64'(out_valid_o), 64'(0));
        tick();
        buf_free_i = 3'd4;
        settle();
        chk_lanes("R6 pc kept when buffer full", 4, 32'h140);
        tick();
    endtask

    task automatic t_squash();
        squash_i = 1'b1; squash_pc_i = 32'h208;
        settle();
        chk_quiet("R8 squash cycle");
        tick();
        squash_i = 1'b0;
        settle();
        chk("R8 refetch after squash", 64'(req_valid_o), 64'(1));
        chk("R8 refetch addr", 64'(req_addr_o), 64'h200);
        chk("R8 tag advanced", 64'(req_tag_o), 64'(1));
        req_accept_i = 1'b1;
        tick();
        req_accept_i = 1'b0;
        squash_i = 1'b1; squash_pc_i = 32'h300;
        tick();
        squash_i = 1'b0;
        settle();
        chk("R8 pending miss dropped", 64'(req_addr_o), 64'h300);
        chk("R8 second tag", 64'(req_tag_o), 64'(2));
        rsp_valid_i = 1'b1; rsp_tag_i = 2'd1; rsp_line_i = mk_line(32'h200);
        req_accept_i = 1'b1;
        tick();
        rsp_valid_i = 1'b0; req_accept_i = 1'b0;
        settle();
        chk("R8 late response stale", 64'(stale_cnt_o), 64'(2));
        chk("R2 lines accepted", 64'(line_cnt_o), 64'(4));
    endtask

    task automatic t_rename();
        regs_empty_i = 1'b1; barrier_hold_i = 1'b1;
        rsp_valid_i = 1'b1; rsp_tag_i = 2'd2; rsp_line_i = mk_line(32'h300);
        tick();
        rsp_valid_i = 1'b0;
        settle();
        chk_quiet("R5 rename hold");
        regs_empty_i = 1'b0;
        tick();
        chk_lanes("R5 rename hold has priority", 4, 32'h300);
        barrier_hold_i = 1'b0;
        tick();
    endtask

    task automatic t_fault();
        squash_i = 1'b1; squash_pc_i = 32'h400;
        tick();
        squash_i = 1'b0;
        xlate_fault_i = 1'b1;
        settle();
        chk("R10 single record", 64'(out_valid_o), 64'(1));
        chk("R10 fault flag", 64'(out_fault_o), 64'(1));
        chk("R10 record pc", 64'(out_pc_o[31:0]), 64'h400);
        chk("R10 no request", 64'(req_valid_o), 64'(0));
        tick();
        xlate_fault_i = 1'b0;
        settle();
        chk_quiet("R10 trap pending");
        tick();
        chk_quiet("R10 trap still pending");
        squash_i = 1'b1; squash_pc_i = 32'h500;
        tick();
        squash_i = 1'b0;
        settle();
        chk("R10 squash leaves trap", 64'(req_valid_o), 64'(1));
        chk("R10 squash addr", 64'(req_addr_o), 64'h500);
        chk("R8 tag wraps", 64'(req_tag_o), 64'(0));
    endtask

    initial begin
        t_reset();
        t_first_line();
        t_extract();
        t_retry();
        t_barrier();
        t_squash();
        t_rename();
        t_fault();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule